// File: doc/BRIEF.md
# Flash Write-Cycle Protection Gate

This block sits between the control pins of a parallel NOR-style flash command port and the command state machine behind it. It samples the active-low chip enable, output enable and write enable pins on a system clock. From them it decides when a host write is genuine, and it then gives the command register a single-cycle latch pulse. A write counts as genuine only when the strobe has been low for a minimum number of clocks and output enable has stayed high throughout. The strobe is low when chip enable and write enable are both low. The latch pulse is issued on the strobe's rising edge.

The gate also takes a supply-good level from an external lockout comparator and a power-on reset. While the supply is low the command register is held closed, and writes in progress are dropped. The gate pulses a read-mode reset request on power-on reset and each time the supply falls. After power-on, and after each supply recovery, commands stay shut out until the strobe has been seen high once. A write that was already held low while the supply came up therefore cannot latch on its release.

A state machine holds the gate's condition, with six states:

- `ST_LOCK`: the supply is low.
- `ST_HOLD`: the supply is good, but the strobe has not yet been seen high.
- `ST_IDLE`: ready for a write.
- `ST_COUNT`: the strobe is low and its width is being measured.
- `ST_ARMED`: the width has been met, and the gate waits for the rising edge.
- `ST_BLOCK`: the strobe is low but the cycle was disqualified.

The transitions are as follows:

- Any state goes to LOCK when the supply is low.
- LOCK goes to HOLD once the supply is good.
- HOLD goes to IDLE when the strobe is high.
- IDLE goes to COUNT, or to ARMED when the window is one cycle, when a qualified low is seen. IDLE goes to BLOCK when the strobe is low with output enable low.
- COUNT goes to IDLE on an early rise, which is a glitch. COUNT goes to BLOCK when output enable falls, and to ARMED when the count is reached.
- ARMED goes to IDLE on the rise, and emits the latch pulse. ARMED goes to BLOCK when output enable falls.
- BLOCK goes to IDLE when the strobe is high.

Top module: `wprot_gate`

## Requirements
- R1: While power-on reset is held, cmd_latch, read_reset and cmd_enable are all 0.
- R2: A strobe held low for at least GLITCH_CYCLES clocks with oe_n high gives exactly one cmd_latch pulse, one clock wide. The pulse is high in the third clock after the strobe's rising edge: two synchronizer stages plus the output register.
- R3: If oe_n is low in any sampled cycle while the strobe is low, that strobe produces no cmd_latch.
- R4: A strobe low for GLITCH_CYCLES-1 clocks or fewer produces no cmd_latch. A strobe low for exactly GLITCH_CYCLES clocks produces one.
- R5: The strobe is low only while ce_n and we_n are both 0. The pulse fires when whichever of the two rises first ends the strobe. ce_n low with we_n high, or the reverse, never latches.
- R6: While supply_ok is low, cmd_enable is 0 and no cmd_latch is produced. A write that was armed when the supply fell is discarded.
- R7: read_reset is a one-clock pulse in the first clock after power-on reset ends. It also pulses three clocks after each falling edge of supply_ok.
- R8: If ce_n and we_n are low when power comes up, releasing them does not latch. cmd_enable stays 0 until the strobe has been seen high with the supply good.
- R9: After the supply recovers, the same rule applies: a strobe held low through the recovery is ignored, and later writes latch normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| supply_ok | input | 1 | Supply above lockout level, from comparator, asynchronous |
| cmd_latch | output | 1 | One-clock command-latch strobe |
| read_reset | output | 1 | One-clock request to force array-read mode |
| cmd_enable | output | 1 | Command register open for writes |

## Verification
A wrong state shows at the ports within a few clocks. If the machine sits in the wrong state, cmd_enable disagrees with the model on the clock after the bad transition. If the width count is off by one, a boundary-length strobe either latches when it should not or misses its pulse three clocks after release. A lost hold on power-up or on recovery shows as a spurious cmd_latch on the first release. The bench compares all three outputs with a behavioural model on every clock, so any divergence is reported in the cycle it appears.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    // Gate condition states
    typedef enum logic [2:0] {
        ST_LOCK  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_IDLE  = 3'd2,
        ST_COUNT = 3'd3,
        ST_ARMED = 3'd4,
        ST_BLOCK = 3'd5
    } wp_state_e;

    // Bit positions in the synchronized pin vector
    localparam int PIN_CE  = 0;
    localparam int PIN_OE  = 1;
    localparam int PIN_WE  = 2;
    localparam int PIN_SUP = 3;
    localparam int PIN_W   = 4;

    // Synchronizer reset: strobe pins read as low (a write assumed held),
    // output enable high, supply low. This makes power-up conservative.
    localparam logic [PIN_W-1:0] PIN_RST = 4'b0010;

    function automatic logic st_cmd_open(wp_state_e s);
        return (s == ST_IDLE) || (s == ST_COUNT) ||
               (s == ST_ARMED) || (s == ST_BLOCK);
    endfunction

endpackage

// File: rtl/wprot_sync.sv
module wprot_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wprot_width_cnt.sv
module wprot_width_cnt #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic inc,
    output logic at_limit
);

    localparam int            CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= ONE;
        else if (inc)  cnt <= cnt + ONE;
    end

    assign at_limit = (cnt == LAST);

endmodule

// File: rtl/wprot_rr_pulse.sv
module wprot_rr_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_s,
    output logic rr
);

    logic boot_q;
    logic sup_q;
    logic rr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_q <= 1'b1;
            sup_q  <= 1'b0;
            rr_q   <= 1'b0;
        end else begin
            boot_q <= 1'b0;
            sup_q  <= sup_s;
            rr_q   <= boot_q | (sup_q & ~sup_s);
        end
    end

    assign rr = rr_q;

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
    parameter int GLITCH_CYCLES = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic supply_ok,
    output logic cmd_latch,
    output logic read_reset,
    output logic cmd_enable
);
    import wprot_pkg::*;

    localparam bit SHORT_WIN = (GLITCH_CYCLES <= 1);

    logic [PIN_W-1:0] pins_raw;
    logic [PIN_W-1:0] pins_s;
    logic ce_s, oe_s, we_s, sup_s;
    logic strobe_low, strobe_high, wr_ok;

    wp_state_e st, nxt;
    logic cnt_load, cnt_inc, at_limit, latch_set;
    logic cmd_latch_q, cmd_en_q;

    assign pins_raw = {supply_ok, we_n, oe_n, ce_n};

    wprot_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    assign ce_s  = pins_s[PIN_CE];
    assign oe_s  = pins_s[PIN_OE];
    assign we_s  = pins_s[PIN_WE];
    assign sup_s = pins_s[PIN_SUP];

    assign strobe_low  = ~ce_s & ~we_s;
    assign strobe_high = ~strobe_low;
    assign wr_ok       = strobe_low & oe_s;

    wprot_width_cnt #(
        .LIMIT (GLITCH_CYCLES)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .inc      (cnt_inc),
        .at_limit (at_limit)
    );

    wprot_rr_pulse u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .sup_s (sup_s),
        .rr    (read_reset)
    );

    // Next-state logic
    always_comb begin
        nxt       = st;
        cnt_load  = 1'b0;
        cnt_inc   = 1'b0;
        latch_set = 1'b0;
        if (!sup_s) begin
            nxt = ST_LOCK;
        end else begin
            unique case (st)
                ST_LOCK: nxt = ST_HOLD;
                ST_HOLD: begin
                    if (strobe_high) nxt = ST_IDLE;
                end
                ST_IDLE: begin
                    if (wr_ok) begin
                        cnt_load = 1'b1;
                        nxt      = SHORT_WIN ? ST_ARMED : ST_COUNT;
                    end else if (strobe_low) begin
                        nxt = ST_BLOCK;
                    end
                end
                ST_COUNT: begin
                    if (strobe_high)   nxt = ST_IDLE;
                    else if (!oe_s)    nxt = ST_BLOCK;
                    else if (at_limit) nxt = ST_ARMED;
                    else               cnt_inc = 1'b1;
                end
                ST_ARMED: begin
                    if (strobe_high) begin
                        nxt       = ST_IDLE;
                        latch_set = 1'b1;
                    end else if (!oe_s) begin
                        nxt = ST_BLOCK;
                    end
                end
                ST_BLOCK: begin
                    if (strobe_high) nxt = ST_IDLE;
                end
                default: nxt = ST_LOCK;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_LOCK;
        else        st <= nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_latch_q <= 1'b0;
            cmd_en_q    <= 1'b0;
        end else begin
            cmd_latch_q <= latch_set;
            cmd_en_q    <= st_cmd_open(nxt);
        end
    end

    assign cmd_latch  = cmd_latch_q;
    assign cmd_enable = cmd_en_q;

endmodule

// File: rtl/wprot_gate_chk.sv
module wprot_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_latch,
    input logic read_reset,
    input logic cmd_enable,
    input logic ce_s,
    input logic we_s,
    input logic sup_s
);

    // R2
    latch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_latch |=> !cmd_latch);

    // R7
    rr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_reset |=> !read_reset);

    // R6
    closed_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_enable |-> !cmd_latch);

    // R6
    sup_low_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> !cmd_enable);

    // R8
    open_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_enable) |-> $past(ce_s | we_s));

    // R5
    latch_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_latch |-> $past(ce_s | we_s));

endmodule

bind wprot_gate wprot_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_latch  (cmd_latch),
    .read_reset (read_reset),
    .cmd_enable (cmd_enable),
    .ce_s       (ce_s),
    .we_s       (we_s),
    .sup_s      (sup_s)
);

// File: tb/tb_wprot_gate.sv
`timescale 1ns/1ps
module tb_wprot_gate;

    localparam int N = 3;
    localparam int M_LOCK = 0, M_HOLD = 1, M_IDLE = 2, M_COUNT = 3, M_ARMED = 4, M_BLOCK = 5;

    logic clk = 1'b0;
    logic rst_n, ce_n, oe_n, we_n, supply_ok;
    logic cmd_latch, read_reset, cmd_enable;

    always #2.5 clk = ~clk;

    wprot_gate #(.GLITCH_CYCLES(N), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .supply_ok(supply_ok), .cmd_latch(cmd_latch),
        .read_reset(read_reset), .cmd_enable(cmd_enable)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: pin pipeline as a queue plus a mode integer
    logic [3:0] pq[$];
    int  mode = M_LOCK;
    int  run  = 0;
    bit  boot = 1'b1, sup_prev = 1'b0;
    bit  e_latch = 1'b0, e_rr = 1'b0, e_en = 1'b0;
    logic [3:0] sv;
    bit  mlow, moe, msup;

    initial begin
        pq.push_back(4'b0010);
        pq.push_back(4'b0010);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pq.delete();
            pq.push_back(4'b0010);
            pq.push_back(4'b0010);
            mode = M_LOCK; run = 0; boot = 1'b1; sup_prev = 1'b0;
            e_latch = 1'b0; e_rr = 1'b0; e_en = 1'b0;
        end else begin
            sv = pq.pop_front();
            pq.push_back({supply_ok, we_n, oe_n, ce_n});
            msup = sv[3];
            moe  = sv[1];
            mlow = !sv[0] && !sv[2];
            e_latch = 1'b0;
            e_rr = boot || (sup_prev && !msup);
            boot = 1'b0;
            sup_prev = msup;
            if (!msup) mode = M_LOCK;
            else case (mode)
                M_LOCK:  mode = M_HOLD;
                M_HOLD:  if (!mlow) mode = M_IDLE;
                M_IDLE:  if (mlow && moe) begin run = 1; mode = (N <= 1) ? M_ARMED : M_COUNT; end
                         else if (mlow) mode = M_BLOCK;
                M_COUNT: if (!mlow) mode = M_IDLE;
                         else if (!moe) mode = M_BLOCK;
                         else if (run >= N - 1) mode = M_ARMED;
                         else run++;
                M_ARMED: if (!mlow) begin e_latch = 1'b1; mode = M_IDLE; end
                         else if (!moe) mode = M_BLOCK;
                default: if (!mlow) mode = M_IDLE;
            endcase
            e_en = (mode >= M_IDLE);
        end
    end

    int latch_seen = 0, rr_seen = 0;
    realtime lat_t = 0.0, rr_t = 0.0;

    always @(negedge clk) begin
        chk(cmd_latch == e_latch, cur_req, "cmd_latch vs model", cmd_latch, e_latch);
        chk(read_reset == e_rr, "R7", "read_reset vs model", read_reset, e_rr);
        chk(cmd_enable == e_en, cur_req, "cmd_enable vs model", cmd_enable, e_en);
        if (cmd_latch) begin latch_seen++; lat_t = $realtime; end
        if (read_reset) begin rr_seen++; rr_t = $realtime; end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int low_cyc, output realtime rel);
        ce_n = 1'b0; we_n = 1'b0;
        idle(low_cyc);
        rel = $realtime;
        ce_n = 1'b1; we_n = 1'b1;
        idle(8);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20000 * 5);
        fails++;
        $display("FAIL R2 watchdog expired: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int base, rbase, d;
        realtime rel;
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; supply_ok = 1'b0; rst_n = 1'b0;
        idle(3);
        // R1 reset state
        chk(cmd_latch == 1'b0, "R1", "cmd_latch in reset", cmd_latch, 0);
        chk(read_reset == 1'b0, "R1", "read_reset in reset", read_reset, 0);
        chk(cmd_enable == 1'b0, "R1", "cmd_enable in reset", cmd_enable, 0);
        rbase = rr_seen;
        rst_n = 1'b1;
        idle(5);
        chk(rr_seen - rbase == 1, "R7", "read_reset pulses after reset", rr_seen - rbase, 1);

        // R8 write held through power-up
        cur_req = "R8";
        supply_ok = 1'b1;
        idle(8);
        chk(cmd_enable == 1'b0, "R8", "cmd_enable while held low", cmd_enable, 0);
        base = latch_seen;
        ce_n = 1'b1; we_n = 1'b1;
        idle(8);
        chk(latch_seen - base == 0, "R8", "no latch on power-up release", latch_seen - base, 0);
        chk(cmd_enable == 1'b1, "R8", "cmd_enable after high seen", cmd_enable, 1);

        // R2 normal write and latency
        cur_req = "R2";
        base = latch_seen;
        strobe(5, rel);
        chk(latch_seen - base == 1, "R2", "one-cycle latch count", latch_seen - base, 1);
        d = int'((lat_t - rel) * 1000.0);
        chk(d == 15000, "R2", "latch delay ps", d, 15000);

        // R4 width boundary
        cur_req = "R4";
        base = latch_seen;
        strobe(N - 1, rel);
        chk(latch_seen - base == 0, "R4", "short strobe no latch", latch_seen - base, 0);
        base = latch_seen;
        strobe(1, rel);
        chk(latch_seen - base == 0, "R4", "one-cycle glitch no latch", latch_seen - base, 0);
        base = latch_seen;
        strobe(N, rel);
        chk(latch_seen - base == 1, "R4", "exact width latches", latch_seen - base, 1);

        // R3 output enable low
        cur_req = "R3";
        base = latch_seen;
        oe_n = 1'b0;
        strobe(6, rel);
        oe_n = 1'b1;
        chk(latch_seen - base == 0, "R3", "oe low whole strobe", latch_seen - base, 0);
        base = latch_seen;
        ce_n = 1'b0; we_n = 1'b0;
        idle(5); oe_n = 1'b0; idle(1); oe_n = 1'b1; idle(2);
        ce_n = 1'b1; we_n = 1'b1;
        idle(8);
        chk(latch_seen - base == 0, "R3", "oe dip mid strobe", latch_seen - base, 0);

        // R5 combined strobe
        cur_req = "R5";
        base = latch_seen;
        ce_n = 1'b0; idle(6); ce_n = 1'b1; idle(6);
        we_n = 1'b0; idle(6); we_n = 1'b1; idle(6);
        chk(latch_seen - base == 0, "R5", "single pin low no latch", latch_seen - base, 0);
        base = latch_seen;
        ce_n = 1'b0; idle(2); we_n = 1'b0; idle(5); we_n = 1'b1; idle(2); ce_n = 1'b1; idle(6);
        chk(latch_seen - base == 1, "R5", "we-ended write", latch_seen - base, 1);
        base = latch_seen;
        we_n = 1'b0; idle(2); ce_n = 1'b0; idle(5); ce_n = 1'b1; idle(2); we_n = 1'b1; idle(6);
        chk(latch_seen - base == 1, "R5", "ce-ended write", latch_seen - base, 1);

        // R6 supply drop during armed write
        cur_req = "R6";
        base = latch_seen; rbase = rr_seen;
        ce_n = 1'b0; we_n = 1'b0; idle(6);
        rel = $realtime;
        supply_ok = 1'b0; idle(2);
        ce_n = 1'b1; we_n = 1'b1; idle(8);
        chk(latch_seen - base == 0, "R6", "armed write dropped", latch_seen - base, 0);
        chk(cmd_enable == 1'b0, "R6", "cmd_enable when supply low", cmd_enable, 0);
        chk(rr_seen - rbase == 1, "R7", "read_reset on supply fall", rr_seen - rbase, 1);
        d = int'((rr_t - rel) * 1000.0);
        chk(d == 15000, "R7", "read_reset delay ps", d, 15000);
        base = latch_seen;
        strobe(6, rel);
        chk(latch_seen - base == 0, "R6", "write ignored while low", latch_seen - base, 0);

        // R9 recovery
        cur_req = "R9";
        supply_ok = 1'b1; idle(8);
        base = latch_seen;
        strobe(5, rel);
        chk(latch_seen - base == 1, "R9", "write after clean recovery", latch_seen - base, 1);
        supply_ok = 1'b0; idle(6);
        ce_n = 1'b0; we_n = 1'b0;
        supply_ok = 1'b1; idle(8);
        chk(cmd_enable == 1'b0, "R9", "closed while strobe held", cmd_enable, 0);
        base = latch_seen;
        ce_n = 1'b1; we_n = 1'b1; idle(8);
        chk(latch_seen - base == 0, "R9", "held strobe ignored", latch_seen - base, 0);
        base = latch_seen;
        strobe(5, rel);
        chk(latch_seen - base == 1, "R9", "next write latches", latch_seen - base, 1);

        // Mixed traffic against the model
        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            ce_n = ($urandom_range(0, 3) == 0);
            we_n = ($urandom_range(0, 2) == 0);
            oe_n = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 59) == 0) supply_ok = ~supply_ok;
            idle($urandom_range(1, 5));
        end
        supply_ok = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(10);
        finish_run();
    end

endmodule